// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block is the forwarding-select logic of a five-stage in-order integer pipeline. It looks at the source register numbers of the instruction now in decode and compares them against the destinations of the three instructions further down the pipe: the one in execute, the one in memory and the one in writeback. For each source it returns a two-bit select code. The operand muxes in front of the execute-stage operand latches use that code, and so do the equality comparator that resolves branches in decode. Both consumers read the same code.

When several in-flight instructions write the register being read, the youngest writer wins. The youngest writer is the one in the nearest later stage. The block also raises one flag, `no_fwd`, for the stall logic. It goes high when the needed value does not yet exist anywhere in the datapath. That happens for a load still in execute, whose data has not left memory yet. It also happens for a decode-stage branch whose operand is still being computed in execute. The block is purely combinational. The datapath registers, the ALU and the register file are outside it.

Top module: `bypass_select`

## Requirements
- R1: A source register that no later stage writes gets select code 2'b00 (register file).
- R2: A source register number of 0 always gets select 2'b00 and never causes `no_fwd`, whatever the in-flight destinations are.
- R3: A stage is a forwarding candidate only if its write enable is 1 and its destination equals the source number. A matching destination with the enable at 0 is ignored.
- R4: When the youngest matching writer is in execute, the select is 2'b01.
- R5: When the youngest matching writer is in memory, the select is 2'b10. The datapath then picks load data or the ALU result there.
- R6: When the only matching writer is in writeback, the select is 2'b11. This covers a decode read of a register that is being written in the same cycle.
- R7: Among several matching writers, the priority is execute over memory over writeback.
- R8: `no_fwd` is 1 when, for any source, the youngest matching writer is a load in execute (`ex_load`=1). A load in execute that matches no source does not raise it.
- R9: With `dec_branch`=1, `no_fwd` is 1 when, for any source, the youngest matching writer is in execute, even if that writer is not a load. With `dec_branch`=0 and a non-load writer, `no_fwd` stays 0.
- R10: With `dec_branch`=1, a youngest writer in memory (load or not) or in writeback does not raise `no_fwd`.
- R11: The select codes of the two sources are computed independently. Index 0 of `op_sel` belongs to `dec_src[0]`, index 1 to `dec_src[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src | input | NUM_SRC x REG_AW (2x5) | Source register numbers of the decode-stage instruction |
| dec_branch | input | 1 | Decode-stage instruction is a branch comparing its sources |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | REG_AW | Execute-stage destination register |
| ex_load | input | 1 | Execute-stage instruction is a load (memory-to-register) |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_AW | Memory-stage destination register |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | REG_AW | Writeback-stage destination register |
| op_sel | output | NUM_SRC x 2 | Per-source select: 00 file, 01 execute, 10 memory, 11 writeback |
| no_fwd | output | 1 | Value not forwardable this cycle; request a stall |

## Verification
The bench targets the following corner cases:

- **Several writers of the same register.** A selector that ranks by stage in the wrong order would hand an older, stale value to the consumer.
- **Register 0 named as a destination.** A design without the zero filter would forward junk into a read that must return zero.
- **A disabled stage whose destination still matches.** A design that ignores the write enable would forward from a stage that is not writing.
- **A load in execute, with and without a dependent source.** A design that gets this wrong either lets the consumer read a value memory has not produced, or stalls needlessly.
- **Branches with a writer in execute, memory or writeback.** This separates a correct comparator stall from a missed one and from a spurious one.

A randomized sweep over a small register range then piles collisions on top of these cases.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  localparam int SEL_W = 2;
  localparam int NUM_STAGES = 3;   // hit bit 0: execute, 1: memory, 2: writeback

  typedef enum logic [SEL_W-1:0] {
    FWD_RF  = 2'b00,
    FWD_EX  = 2'b01,
    FWD_MEM = 2'b10,
    FWD_WB  = 2'b11
  } fwd_sel_e;

  // Youngest writer first: nearest later stage has the lowest hit index.
  function automatic fwd_sel_e pick_youngest(input logic [NUM_STAGES-1:0] hit);
    if (hit[0])      return FWD_EX;
    else if (hit[1]) return FWD_MEM;
    else if (hit[2]) return FWD_WB;
    else             return FWD_RF;
  endfunction

  // A candidate must write, target the source, and the source must be non-zero.
  function automatic logic reg_match(input logic wen, input logic [7:0] dst,
                                     input logic [7:0] src);
    return wen && (dst == src) && (src != '0);
  endfunction

endpackage

// File: rtl/bypass_hit.sv
module bypass_hit
  import bypass_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0]                  src,
  input  logic [NUM_STAGES-1:0]              wen,
  input  logic [NUM_STAGES-1:0][REG_AW-1:0]  dst,
  output logic [NUM_STAGES-1:0]              hit
);

  localparam int PADW = 8 - REG_AW;

  for (genvar st = 0; st < NUM_STAGES; st++) begin : g_stage
    assign hit[st] = reg_match(wen[st], {{PADW{1'b0}}, dst[st]},
                               {{PADW{1'b0}}, src});
  end

endmodule

// File: rtl/bypass_rank.sv
module bypass_rank
  import bypass_pkg::*;
(
  input  logic [NUM_STAGES-1:0] hit,
  input  logic                  ex_is_load,
  input  logic                  for_branch,
  output logic [SEL_W-1:0]      sel,
  output logic                  stall
);

  fwd_sel_e choice;
  logic     youngest_in_ex;

  assign choice         = pick_youngest(hit);
  assign youngest_in_ex = (choice == FWD_EX);
  assign sel            = choice;
  assign stall          = youngest_in_ex && (ex_is_load || for_branch);

  // Any hit must leave the register file path (R1/R7 relation between hit and sel).
  always_comb begin
    assert_hit_leaves_rf_R7: assert (hit == '0 || sel != FWD_RF)
      else $error("hit without forwarding select");
  end

endmodule

// File: rtl/bypass_select.sv
module bypass_select
  import bypass_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] dec_src,
  input  logic                           dec_branch,
  input  logic                           ex_wen,
  input  logic [REG_AW-1:0]              ex_dst,
  input  logic                           ex_load,
  input  logic                           mem_wen,
  input  logic [REG_AW-1:0]              mem_dst,
  input  logic                           wb_wen,
  input  logic [REG_AW-1:0]              wb_dst,
  output logic [NUM_SRC-1:0][SEL_W-1:0]  op_sel,
  output logic                           no_fwd
);

  logic [NUM_STAGES-1:0]             stage_wen;
  logic [NUM_STAGES-1:0][REG_AW-1:0] stage_dst;
  logic [NUM_SRC-1:0]                src_stall;

  assign stage_wen = {wb_wen, mem_wen, ex_wen};
  assign stage_dst = {wb_dst, mem_dst, ex_dst};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [NUM_STAGES-1:0] hit;

    bypass_hit #(.REG_AW(REG_AW)) u_hit (
      .src (dec_src[s]),
      .wen (stage_wen),
      .dst (stage_dst),
      .hit (hit)
    );

    bypass_rank u_rank (
      .hit        (hit),
      .ex_is_load (ex_load),
      .for_branch (dec_branch),
      .sel        (op_sel[s]),
      .stall      (src_stall[s])
    );

    always_comb begin
      assert_zero_src_rf_R2: assert (dec_src[s] != '0 || op_sel[s] == FWD_RF)
        else $error("register 0 forwarded");
      assert_ex_sel_needs_match_R4: assert (op_sel[s] != FWD_EX ||
                                            (ex_wen && ex_dst == dec_src[s]))
        else $error("execute select without matching writer");
      assert_mem_sel_youngest_R7: assert (op_sel[s] != FWD_MEM ||
                                          (mem_wen && mem_dst == dec_src[s] &&
                                           !(ex_wen && ex_dst == dec_src[s])))
        else $error("memory select while execute matches");
      assert_wb_sel_only_R6: assert (op_sel[s] != FWD_WB ||
                                     (wb_wen && wb_dst == dec_src[s] &&
                                      !(mem_wen && mem_dst == dec_src[s])))
        else $error("writeback select while memory matches");
    end
  end

  assign no_fwd = |src_stall;

  always_comb begin
    assert_stall_has_cause_R8: assert (!no_fwd || (ex_load || dec_branch))
      else $error("stall without load or branch");
    assert_stall_from_ex_R9: assert (!no_fwd || (op_sel[0] == FWD_EX) ||
                                     (op_sel[NUM_SRC-1] == FWD_EX))
      else $error("stall while no source selects execute");
  end

endmodule

// File: tb/bypass_select_bench.sv
`timescale 1ns/1ps
module bypass_select_bench;
  import bypass_pkg::*;

  localparam int AW = 5;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NS-1:0][AW-1:0] dec_src = '0;
  logic dec_branch = 1'b0, ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic [AW-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic [NS-1:0][1:0] op_sel;
  logic no_fwd;

  bypass_select u_bypass_select (
    .dec_src(dec_src), .dec_branch(dec_branch),
    .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_load(ex_load),
    .mem_wen(mem_wen), .mem_dst(mem_dst),
    .wb_wen(wb_wen), .wb_dst(wb_dst),
    .op_sel(op_sel), .no_fwd(no_fwd)
  );

  typedef struct {
    logic [1:0] e0;
    logic [1:0] e1;
    logic       enf;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference from the requirements: priority ex > mem > wb, reg 0 never forwards.
  function automatic logic [1:0] ref_sel(input logic [AW-1:0] s);
    if (s == 0) return 2'b00;
    if (ex_wen && ex_dst == s) return 2'b01;
    if (mem_wen && mem_dst == s) return 2'b10;
    if (wb_wen && wb_dst == s) return 2'b11;
    return 2'b00;
  endfunction

  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic br,
                       input logic ew, input logic [AW-1:0] ed, input logic el,
                       input logic mw, input logic [AW-1:0] md,
                       input logic ww, input logic [AW-1:0] wd,
                       input logic [1:0] e0, input logic [1:0] e1, input logic enf,
                       input string tag);
    exp_t it;
    @(posedge clk); #1;
    dec_src[0] = a; dec_src[1] = b; dec_branch = br;
    ex_wen = ew; ex_dst = ed; ex_load = el;
    mem_wen = mw; mem_dst = md; wb_wen = ww; wb_dst = wd;
    it.e0 = e0; it.e1 = e1; it.enf = enf; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (op_sel[0] !== it.e0 || op_sel[1] !== it.e1 || no_fwd !== it.enf) begin
        fails++;
        $display("FAIL %s: sel0=%b sel1=%b nf=%b expected sel0=%b sel1=%b nf=%b",
                 it.tag, op_sel[0], op_sel[1], no_fwd, it.e0, it.e1, it.enf);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state inputs: nothing in flight (R1)
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R1 reset state");
    drive(3, 4, 0, 1, 7, 0, 1, 8, 1, 9, 2'b00, 2'b00, 0, "R1 no match");
    drive(0, 0, 1, 1, 0, 1, 1, 0, 1, 0, 2'b00, 2'b00, 0, "R2 register zero");
    drive(5, 6, 0, 0, 5, 1, 0, 6, 0, 5, 2'b00, 2'b00, 0, "R3 disabled writers ignored");
    drive(8, 9, 0, 1, 8, 0, 0, 0, 0, 0, 2'b01, 2'b00, 0, "R4 execute forward");
    drive(11, 10, 0, 0, 0, 0, 1, 10, 0, 0, 2'b00, 2'b10, 0, "R5 memory forward");
    drive(13, 1, 0, 0, 0, 0, 0, 0, 1, 13, 2'b11, 2'b00, 0, "R6 writeback same cycle");
    drive(2, 2, 0, 1, 2, 0, 1, 2, 1, 2, 2'b01, 2'b01, 0, "R7 all three match");
    drive(2, 3, 0, 1, 9, 0, 1, 2, 1, 2, 2'b10, 2'b00, 0, "R7 memory over writeback");
    drive(4, 4, 0, 1, 4, 1, 0, 0, 0, 0, 2'b01, 2'b01, 1, "R8 load in execute");
    drive(5, 4, 0, 1, 4, 1, 1, 4, 0, 0, 2'b00, 2'b01, 1, "R8 load hides older writer");
    drive(5, 6, 0, 1, 4, 1, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R8 unrelated load");
    drive(7, 3, 1, 1, 7, 0, 0, 0, 0, 0, 2'b01, 2'b00, 1, "R9 branch needs execute value");
    drive(7, 3, 0, 1, 7, 0, 0, 0, 0, 0, 2'b01, 2'b00, 0, "R9 non-branch alu forward");
    drive(7, 8, 1, 0, 0, 0, 1, 7, 1, 8, 2'b10, 2'b11, 0, "R10 branch from mem and wb");
    drive(14, 15, 0, 1, 14, 0, 1, 15, 0, 0, 2'b01, 2'b10, 0, "R11 independent sources");
    // randomized sweep with small register range (R7 priority under collisions)
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a, b, ed, md, wd;
      logic br, ew, el, mw, ww;
      logic [1:0] s0, s1;
      logic nf;
      a = AW'($urandom_range(0, 3)); b = AW'($urandom_range(0, 3));
      ed = AW'($urandom_range(0, 3)); md = AW'($urandom_range(0, 3));
      wd = AW'($urandom_range(0, 3));
      br = 1'($urandom); ew = 1'($urandom); el = 1'($urandom);
      mw = 1'($urandom); ww = 1'($urandom);
      @(posedge clk); #1;
      dec_src[0] = a; dec_src[1] = b; dec_branch = br;
      ex_wen = ew; ex_dst = ed; ex_load = el;
      mem_wen = mw; mem_dst = md; wb_wen = ww; wb_dst = wd;
      s0 = ref_sel(a); s1 = ref_sel(b);
      nf = (s0 == 2'b01 || s1 == 2'b01) && (el || br);
      begin
        exp_t it;
        it.e0 = s0; it.e1 = s1; it.enf = nf; it.tag = "R7 random sweep";
        q.push_back(it);
      end
    end
    wait (q.size() == 0);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule